// File: doc/BRIEF.md
# Serial Byte Transmitter with Programmable Stop Gap

This block drives an asynchronous start/stop serial line. Each character goes out as one low start bit, eight data bits with the least significant bit first (a high level is a 1), and then a run of high stop time. A baud divisor sets how many system clocks one bit lasts. When no byte is waiting, the line rests high.

There are two ways to load bytes. In byte mode, a CPU register write to the data address starts a frame, and a control bit picks one or two stop bits. In block mode, bytes come from a valid/ready byte source, and the stop time after each byte is taken from a gap register as (gap − 9) bit times. The ready flag (`tx_rdy_o`) rises as soon as the last data bit starts. This lets the next byte be loaded during the stop time, so the next start bit follows the previous stop time with no idle gap. A data write made while the flag is low is dropped and sets a sticky overrun flag.

Register map, with the address on `reg_addr`:
- 0: transmit data, bits 7:0.
- 1: gap, bits 7:0. Reset value 11.
- 2: control. Bit 0 set selects two stop bits in byte mode. Bit 1 set selects block mode. Reset value 0.
- 3: baud divisor in clocks per bit. Reset value is the `DIV_RST` parameter (default 8). A value of 0 acts as 1.

Top module: `sertx_top`

## Requirements
- R1: After reset, the block is in byte mode with one stop bit, the gap is 11 and the divisor is `DIV_RST`. The outputs are `txd_o`=1, `tx_rdy_o`=1, `overrun_o`=0 and `blk_ready`=0.
- R2: A frame is one low start bit, then data bits 0 to 7 in that order (high = 1), then high stop time. Every bit lasts exactly divisor clocks, and a divisor of 0 gives 1-clock bits.
- R3: A write to address 0 while `tx_rdy_o` is high takes the byte. `tx_rdy_o` is low from the next clock edge. From idle, the start bit begins between 1 and divisor clocks after the edge that took the byte.
- R4: In byte mode, the stop time is 1 bit when control bit 0 is 0, and 2 bits when it is 1.
- R5: In block mode (control bit 1 = 1), `blk_ready` follows `tx_rdy_o`, and a byte is taken on a clock edge where `blk_valid` and `blk_ready` are both high. In byte mode, `blk_ready` stays low and `blk_valid` starts nothing.
- R6: In block mode, the stop time is (gap − 9) bit times, where gap is the value at address 1.
- R7: A gap value below 10 behaves as 10, which gives one stop bit time.
- R8: `tx_rdy_o` rises on the first clock of data bit 7 of the frame in progress. It is still low one clock earlier.
- R9: If a byte is waiting when the stop time ends, its start bit begins on the very next clock, with no idle time.
- R10: A write to address 0 while `tx_rdy_o` is low is ignored and does not change the transmitted stream. It sets `overrun_o` from the next edge, and `overrun_o` stays set until reset.
- R11: When no byte is waiting after a frame, the line stays high and `tx_rdy_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | REG_W (16) | Register write data |
| blk_valid | input | 1 | Block-mode byte source has a byte |
| blk_data | input | 8 | Block-mode byte |
| blk_ready | output | 1 | Block-mode byte can be taken |
| txd_o | output | 1 | Serial output line |
| tx_rdy_o | output | 1 | A new byte can be loaded |
| overrun_o | output | 1 | Sticky flag set by a data write that was dropped |

## Verification
A corrupted bit index or shift register shows as a wrong decoded byte, within the frame it affects. A stop counter that is loaded or counted wrongly moves the next start edge, or the return to idle, by whole bit times. It is caught at the end of that frame. A ready/hold flag that is out of step shows up in two ways. It can move the rise of `tx_rdy_o` away from the first clock of bit 7, and the bench checks that clock exactly. Or it can drop or repeat a byte, which the bench sees at the first frame it decodes after the fault.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_GAP  = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  localparam int unsigned GAP_FLOOR = 10;
  localparam int unsigned GAP_BIAS  = 9;

  typedef enum logic [1:0] {
    TS_IDLE,
    TS_START,
    TS_DATA,
    TS_STOP
  } tx_state_e;

  // stop length in bit times for block mode, with the gap floor applied
  function automatic int unsigned block_stop_len(input int unsigned gap);
    int unsigned g;
    g = (gap < GAP_FLOOR) ? GAP_FLOOR : gap;
    return g - GAP_BIAS;
  endfunction

  // stop length in bit times for byte mode
  function automatic int unsigned byte_stop_len(input logic two_stop);
    return two_stop ? 2 : 1;
  endfunction

endpackage

// File: rtl/sertx_regs.sv
module sertx_regs #(
  parameter int REG_W   = 16,
  parameter int GAP_W   = 8,
  parameter int DIV_W   = 16,
  parameter int GAP_RST = 11,
  parameter int DIV_RST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [GAP_W-1:0] gap_q,
  output logic [DIV_W-1:0] div_q,
  output logic             two_stop_q,
  output logic             blk_mode_q,
  output logic             data_wr,
  output logic [7:0]       data_byte
);
  import sertx_pkg::*;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  assign data_wr   = we && (addr == A_DATA);
  assign data_byte = wdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q      <= GAP_W'(GAP_RST);
      div_q      <= DIV_W'(DIV_RST);
      two_stop_q <= 1'b0;
      blk_mode_q <= 1'b0;
    end else if (we) begin
      case (addr)
        A_GAP:  gap_q <= wdata[GAP_W-1:0];
        A_CTRL: begin
          two_stop_q <= wdata[0];
          blk_mode_q <= wdata[1];
        end
        A_DIV:  div_q <= wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_q,
  output logic             bit_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;

  assign div_eff  = (div_q == '0) ? DIV_W'(1) : div_q;
  // >= keeps the counter sane when the divisor shrinks mid-count
  assign bit_tick = (cnt_q >= (div_eff - DIV_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (bit_tick) cnt_q <= '0;
    else               cnt_q <= cnt_q + DIV_W'(1);
  end

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             load,
  input  logic [7:0]       load_byte,
  input  logic             two_stop,
  input  logic             blk_mode,
  input  logic [GAP_W-1:0] gap,
  output logic             txd,
  output logic             tx_rdy,
  output logic             enter_last
);
  import sertx_pkg::*;

  tx_state_e        st_q;
  logic [7:0]       hold_q;
  logic [7:0]       shift_q;
  logic             pend_q;
  logic             lock_q;
  logic [2:0]       idx_q;
  logic [GAP_W-1:0] stop_len_q;
  logic [GAP_W-1:0] stop_left_q;
  logic             txd_q;
  logic             stop_done;
  logic             begin_frame;
  logic [GAP_W-1:0] stop_len_next;

  assign stop_done   = (st_q == TS_STOP) && (stop_left_q == GAP_W'(1));
  assign begin_frame = bit_tick && pend_q && ((st_q == TS_IDLE) || stop_done);
  assign enter_last  = bit_tick && (st_q == TS_DATA) && (idx_q == 3'd6);
  assign txd         = txd_q;
  assign tx_rdy      = ~lock_q;

  always_comb begin
    if (blk_mode) stop_len_next = GAP_W'(block_stop_len(32'(gap)));
    else          stop_len_next = GAP_W'(byte_stop_len(two_stop));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= TS_IDLE;
      hold_q      <= '0;
      shift_q     <= '0;
      pend_q      <= 1'b0;
      lock_q      <= 1'b0;
      idx_q       <= '0;
      stop_len_q  <= GAP_W'(1);
      stop_left_q <= GAP_W'(1);
      txd_q       <= 1'b1;
    end else begin
      if (load) begin
        hold_q <= load_byte;
        pend_q <= 1'b1;
        lock_q <= 1'b1;
      end
      if (enter_last) lock_q <= 1'b0;
      if (begin_frame) begin
        st_q       <= TS_START;
        txd_q      <= 1'b0;
        shift_q    <= hold_q;
        pend_q     <= 1'b0;
        stop_len_q <= stop_len_next;
      end else if (bit_tick) begin
        case (st_q)
          TS_START: begin
            st_q  <= TS_DATA;
            idx_q <= 3'd0;
            txd_q <= shift_q[0];
          end
          TS_DATA: begin
            if (idx_q == 3'd7) begin
              st_q        <= TS_STOP;
              txd_q       <= 1'b1;
              stop_left_q <= stop_len_q;
            end else begin
              idx_q <= idx_q + 3'd1;
              txd_q <= shift_q[idx_q + 3'd1];
            end
          end
          TS_STOP: begin
            if (stop_done) st_q <= TS_IDLE;
            else           stop_left_q <= stop_left_q - GAP_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int REG_W   = 16,
  parameter int GAP_W   = 8,
  parameter int DIV_W   = 16,
  parameter int GAP_RST = 11,
  parameter int DIV_RST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             blk_valid,
  input  logic [7:0]       blk_data,
  output logic             blk_ready,
  output logic             txd_o,
  output logic             tx_rdy_o,
  output logic             overrun_o
);
  logic [GAP_W-1:0] gap_q;
  logic [DIV_W-1:0] div_q;
  logic             two_stop_q;
  logic             blk_mode_q;
  logic             cpu_data_wr;
  logic [7:0]       cpu_byte;
  logic             bit_tick;
  logic             enter_last;
  logic             cpu_accept;
  logic             blk_accept;
  logic             load;
  logic [7:0]       load_byte;
  logic             ovr_q;

  sertx_regs #(
    .REG_W(REG_W), .GAP_W(GAP_W), .DIV_W(DIV_W),
    .GAP_RST(GAP_RST), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .gap_q(gap_q), .div_q(div_q), .two_stop_q(two_stop_q), .blk_mode_q(blk_mode_q),
    .data_wr(cpu_data_wr), .data_byte(cpu_byte)
  );

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div_q(div_q), .bit_tick(bit_tick)
  );

  // a CPU data write has priority over the block source in the same cycle
  assign cpu_accept = cpu_data_wr && tx_rdy_o;
  assign blk_ready  = blk_mode_q && tx_rdy_o && !cpu_data_wr;
  assign blk_accept = blk_valid && blk_ready;
  assign load       = cpu_accept || blk_accept;
  assign load_byte  = cpu_accept ? cpu_byte : blk_data;

  sertx_frame #(.GAP_W(GAP_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .load(load), .load_byte(load_byte),
    .two_stop(two_stop_q), .blk_mode(blk_mode_q), .gap(gap_q),
    .txd(txd_o), .tx_rdy(tx_rdy_o), .enter_last(enter_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                          ovr_q <= 1'b0;
    else if (cpu_data_wr && !tx_rdy_o)   ovr_q <= 1'b1;
  end
  assign overrun_o = ovr_q;

endmodule

// File: rtl/sertx_checks.sv
module sertx_checks (
  input logic clk,
  input logic rst_n,
  input logic data_wr,
  input logic bit_tick,
  input logic enter_last,
  input logic blk_valid,
  input logic blk_ready,
  input logic tx_rdy,
  input logic txd,
  input logic overrun
);

  // R2: the line only moves on a bit boundary
  assert_txd_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(bit_tick));

  // R3: an accepted data write drops the ready flag
  assert_rdy_falls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_rdy) |=> !tx_rdy);

  // R5: a block handshake drops the ready flag
  assert_blk_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_ready) |=> !tx_rdy);

  // R5: block source is never offered a slot while the flag is low
  assert_blk_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ready |-> tx_rdy);

  // R8: ready returns only at the start of the last data bit
  assert_rdy_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_rdy) |-> $past(enter_last));

  // R10: a dropped write raises overrun
  assert_ovr_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !tx_rdy) |=> overrun);

  // R10: overrun is sticky
  assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(overrun));

endmodule

bind sertx_top sertx_checks u_checks (
  .clk(clk), .rst_n(rst_n), .data_wr(cpu_data_wr), .bit_tick(bit_tick),
  .enter_last(enter_last), .blk_valid(blk_valid), .blk_ready(blk_ready),
  .tx_rdy(tx_rdy_o), .txd(txd_o), .overrun(overrun_o)
);

// File: tb/sertx_top_test.sv
`timescale 1ns/1ps
module sertx_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic        blk_valid = 1'b0;
  logic [7:0]  blk_data = 8'd0;
  logic        blk_ready;
  logic        txd_o;
  logic        tx_rdy_o;
  logic        overrun_o;

  always #2.5 clk = ~clk;

  sertx_top #(.DIV_RST(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .blk_valid(blk_valid), .blk_data(blk_data),
    .blk_ready(blk_ready), .txd_o(txd_o), .tx_rdy_o(tx_rdy_o), .overrun_o(overrun_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] sb [8];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int f_div(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int f_stop(input bit blk, input int gap, input bit two);
    if (blk) return ((gap < 10) ? 10 : gap) - 9;
    return two ? 2 : 1;
  endfunction

  // all tasks are entered just after a falling edge
  task automatic wr(input int a, input int v);
    reg_we = 1'b1; reg_addr = a[1:0]; reg_wdata = v[15:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic blk_send(input logic [7:0] d);
    blk_data = d; blk_valid = 1'b1;
    forever begin
      if (blk_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    blk_valid = 1'b0;
  endtask

  task automatic rx_frame(input logic [7:0] exp_b, input int ns, input int dv,
                          input bit nxt, input bit chk_lat);
    int lat = 0;
    int total;
    logic [7:0] got = 8'h00;
    bit st_ok, stop_ok = 1, idle_ok = 1;
    while (txd_o !== 1'b0 && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    if (chk_lat) chk(lat >= 1 && lat <= dv, "R3 start latency", lat, dv);
    st_ok = (txd_o === 1'b0);
    total = (9 + ns) * dv + (nxt ? 0 : 2 * dv);
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      if (dv > 1 && k == dv / 2 && txd_o !== 1'b0) st_ok = 0;
      if (k >= dv && k < 9 * dv && ((k - dv) % dv) == dv / 2)
        got[(k - dv) / dv] = txd_o;
      if (k == 8 * dv - 1) chk(tx_rdy_o === 1'b0, "R8 ready low before bit 7", int'(tx_rdy_o), 0);
      if (k == 8 * dv)     chk(tx_rdy_o === 1'b1, "R8 ready high at bit 7", int'(tx_rdy_o), 1);
      if (k >= 9 * dv && k < (9 + ns) * dv && txd_o !== 1'b1) stop_ok = 0;
      if (nxt && k == (9 + ns) * dv)
        chk(txd_o === 1'b0, "R9 back-to-back start", int'(txd_o), 0);
      if (!nxt && k >= (9 + ns) * dv && (txd_o !== 1'b1 || tx_rdy_o !== 1'b1)) idle_ok = 0;
    end
    chk(st_ok, "R2 start bit", int'(st_ok), 1);
    chk(got === exp_b, "R2 data bits", int'(got), int'(exp_b));
    chk(stop_ok, "R4 R6 stop length", int'(stop_ok), 1);
    if (!nxt) chk(idle_ok, "R11 idle after frame", int'(idle_ok), 1);
  endtask

  task automatic run_stream(input int n, input int ns, input int dv, input bit blk);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          if (blk) blk_send(sb[i]);
          else begin
            while (!tx_rdy_o) @(negedge clk);
            wr(0, int'(sb[i]));
          end
        end
      end
      begin
        for (int i = 0; i < n; i++) rx_frame(sb[i], ns, dv, i < n - 1, 1'b0);
      end
    join
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    finish_run();
  end

  initial begin
    int dv, gap, ns;
    bit blk, two;
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(txd_o === 1'b1, "R1 txd idle", int'(txd_o), 1);
    chk(tx_rdy_o === 1'b1, "R1 ready", int'(tx_rdy_o), 1);
    chk(overrun_o === 1'b0, "R1 overrun", int'(overrun_o), 0);
    chk(blk_ready === 1'b0, "R1 block ready", int'(blk_ready), 0);

    // R2 R3 R8 R11: single byte, default divisor 8, one stop
    wr(0, 8'hA5);
    rx_frame(8'hA5, 1, 8, 1'b0, 1'b1);

    // R5: block source ignored in byte mode
    begin
      bit ign_ok = 1;
      blk_data = 8'hFF; blk_valid = 1'b1;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (blk_ready !== 1'b0 || txd_o !== 1'b1) ign_ok = 0;
      end
      blk_valid = 1'b0;
      chk(ign_ok, "R5 byte mode ignores block source", int'(ign_ok), 1);
      chk(tx_rdy_o === 1'b1, "R5 ready untouched", int'(tx_rdy_o), 1);
    end

    // R4: two stop bits
    wr(2, 1);
    wr(0, 8'h5A);
    rx_frame(8'h5A, 2, 8, 1'b0, 1'b1);
    wr(2, 0);

    // R2: divisor 0 acts as 1
    wr(3, 0);
    wr(0, 8'h81);
    rx_frame(8'h81, 1, 1, 1'b0, 1'b1);

    // R9: byte-mode back-to-back stream
    wr(3, 5);
    sb[0] = 8'h00; sb[1] = 8'hFF; sb[2] = 8'h6C; sb[3] = 8'h93;
    run_stream(4, 1, 5, 1'b0);

    // R1 R6: block mode with reset gap (2 stop bits)
    wr(2, 2);
    sb[0] = 8'h11; sb[1] = 8'hEE; sb[2] = 8'h42;
    run_stream(3, f_stop(1, 11, 0), 5, 1'b1);

    // R6: gap 15 gives 6 stop bits
    wr(1, 15);
    sb[0] = 8'h7E; sb[1] = 8'h01;
    run_stream(2, f_stop(1, 15, 0), 5, 1'b1);

    // R7: gap 3 and gap 10 both give one stop bit
    wr(1, 3);
    sb[0] = 8'hC0; sb[1] = 8'h3F;
    run_stream(2, f_stop(1, 3, 0), 5, 1'b1);
    wr(1, 10);
    sb[0] = 8'hAA; sb[1] = 8'h55;
    run_stream(2, f_stop(1, 10, 0), 5, 1'b1);

    // random mix of modes, divisors, gaps and stop settings
    for (int it = 0; it < 8; it++) begin
      dv  = 4 + int'($urandom % 7);
      blk = $urandom % 2;
      two = $urandom % 2;
      gap = int'($urandom % 20);
      wr(3, dv);
      wr(1, gap);
      wr(2, {30'd0, blk, two});
      ns = f_stop(blk, gap, two);
      for (int i = 0; i < 3; i++) sb[i] = 8'($urandom);
      run_stream(3, ns, f_div(dv), blk);
    end

    // R10: write while busy is dropped, overrun sticks
    wr(2, 0);
    wr(3, 8);
    wr(0, 8'h3C);
    wr(0, 8'hC3);
    chk(overrun_o === 1'b1, "R10 overrun set", int'(overrun_o), 1);
    rx_frame(8'h3C, 1, 8, 1'b0, 1'b0);
    wr(0, 8'h96);
    rx_frame(8'h96, 1, 8, 1'b0, 1'b1);
    chk(overrun_o === 1'b1, "R10 overrun sticky", int'(overrun_o), 1);

    finish_run();
  end

endmodule